// File: doc/BRIEF.md
# DMA Channel Register File

This block is the software-visible register file of a multi-channel DMA engine. Every channel owns one address window. The window holds a control/status word and six 32-bit pointer and length registers: the current descriptor pointer, the limit, the start, the stop, the initial-buffer pointer and the size. A 32-bit, word-only bus slave decodes the channel from the upper address bits and the register from the offset inside the window. Writes to a pointer register store the value, and reads return it.

The control/status word is not a plain storage register. Its write data carries command bits, and each command acts on one status bit: set run enable, set single-update, set the device-to-memory direction, clear completion, and a channel reset that wipes all four status bits. The transfer engine receives the enable, direction and completion flags of each channel, and it reports the end of a transfer with a one-cycle pulse that sets completion.

A read is combinational. `rdata_o` carries the selected value in the same cycle as the read request and is zero otherwise. A write takes effect at the clock edge that samples it.

Top module: `dma_chan_regs`

## Requirements
- R1: After `rst_ni` is released, every status bit, every pointer register and the `en_o`, `dir_o` and `cmpl_o` outputs are zero.
- R2: The channel number is `addr_i[CH_SHIFT +: CH_BITS]`. Inside a channel window, the offsets are: control/status 0x0, next 0x4000, limit 0x4004, start 0x4008, stop 0x400C, initial-buffer 0x4200, size 0x4204. A word write to a pointer offset stores the data, and a later read of that channel and offset returns it. No other channel and no other register changes.
- R3: A write of the control/status word with bit 0 set sets the enable status (read bit 0). A write with bit 0 clear leaves the enable status as it was.
- R4: A control/status write with bit 1 set sets the single-update status (read bit 1). A write with bit 1 clear leaves it unchanged.
- R5: A control/status write with bit 2 set sets the device-to-memory direction status (read bit 2). A write with bit 2 clear does not clear it.
- R6: A control/status write with bit 4 set clears the complete status (read bit 3) and touches no other status bit.
- R7: A control/status write with bit 5 set clears the enable, single-update, direction and complete status bits together. It takes priority over bits 0, 1 and 2 in the same write.
- R8: A one-cycle pulse on `done_i[c]` sets the complete status of channel c at the next edge. The pulse wins over a clear-complete or reset command to the same channel in the same cycle.
- R9: An access with `size_i` other than 2 (word) is refused: a read returns zero and a write changes nothing.
- R10: A word access to an offset that is not listed in R2, or to an unaligned address, reads zero, and a write to it changes nothing.
- R11: `en_o[c]`, `dir_o[c]` and `cmpl_o[c]` always equal status bits 0, 2 and 3 of channel c. Bits 31..4 of a control/status read are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| addr_i | input | ADDR_W | Byte address: channel above CH_SHIFT, offset below |
| wdata_i | input | 32 | Write data or command bits |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| done_i | input | NUM_CH | Per-channel transfer-complete pulse |
| en_o | output | NUM_CH | Per-channel run enable |
| dir_o | output | NUM_CH | Per-channel direction, 1 = device to memory |
| cmpl_o | output | NUM_CH | Per-channel complete flag |

## Verification
The bench uses the default four channels with a 0x8000-byte window per channel. At that size every channel can be swept in full. All 64 combinations of the six command bits are applied to each channel in sequence, and a bench model of the status bits tracks them. Every pointer register of every channel gets a distinct value and is read back across all channels, so an address decode that aliases channels or registers shows up. The same-cycle collisions between the completion pulse and clear or reset commands are driven directly. So are byte and half-word accesses, and offsets just beside the mapped registers.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int DW = 32;
  localparam int NUM_PTR = 6;

  localparam logic [15:0] OFS_CSR   = 16'h0000;
  localparam logic [15:0] OFS_NEXT  = 16'h4000;
  localparam logic [15:0] OFS_LIMIT = 16'h4004;
  localparam logic [15:0] OFS_START = 16'h4008;
  localparam logic [15:0] OFS_STOP  = 16'h400C;
  localparam logic [15:0] OFS_INIT  = 16'h4200;
  localparam logic [15:0] OFS_SIZE  = 16'h4204;

  // command bits in control write data
  localparam int CMD_SET_EN  = 0;
  localparam int CMD_SET_SUP = 1;
  localparam int CMD_DIR     = 2;
  localparam int CMD_CLR_CPL = 4;
  localparam int CMD_RESET   = 5;

  // status bits in control read data
  localparam int ST_EN  = 0;
  localparam int ST_SUP = 1;
  localparam int ST_DIR = 2;
  localparam int ST_CPL = 3;
  localparam int ST_W   = 4;

  localparam logic [1:0] SIZE_WORD = 2'd2;

  typedef enum logic [2:0] {
    SEL_CSR   = 3'd0,
    SEL_NEXT  = 3'd1,
    SEL_LIMIT = 3'd2,
    SEL_START = 3'd3,
    SEL_STOP  = 3'd4,
    SEL_INIT  = 3'd5,
    SEL_SIZE  = 3'd6,
    SEL_NONE  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int CH_SHIFT = 15,  // must be >= 15 to hold offset 0x4204
  localparam int CH_BITS = $clog2(NUM_CH),
  localparam int ADDR_W  = CH_SHIFT + CH_BITS
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [1:0]         size_i,
  output logic [CH_BITS-1:0] ch_o,
  output reg_sel_e           sel_o
);
  logic [CH_SHIFT-1:0] ofs;
  logic ch_ok;

  assign ofs   = addr_i[CH_SHIFT-1:0];
  assign ch_o  = addr_i[ADDR_W-1:CH_SHIFT];
  assign ch_ok = int'(ch_o) < NUM_CH;

  always_comb begin
    sel_o = SEL_NONE;
    if (size_i == SIZE_WORD && ch_ok) begin
      if      (ofs == CH_SHIFT'(OFS_CSR))   sel_o = SEL_CSR;
      else if (ofs == CH_SHIFT'(OFS_NEXT))  sel_o = SEL_NEXT;
      else if (ofs == CH_SHIFT'(OFS_LIMIT)) sel_o = SEL_LIMIT;
      else if (ofs == CH_SHIFT'(OFS_START)) sel_o = SEL_START;
      else if (ofs == CH_SHIFT'(OFS_STOP))  sel_o = SEL_STOP;
      else if (ofs == CH_SHIFT'(OFS_INIT))  sel_o = SEL_INIT;
      else if (ofs == CH_SHIFT'(OFS_SIZE))  sel_o = SEL_SIZE;
    end
  end

  // R10: unaligned addresses never map
  always_comb begin
    if (addr_i[1:0] != 2'b00) a_r10_unaligned_none : assert (sel_o == SEL_NONE);
  end
endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
  import dma_regs_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  reg_sel_e      sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          done_i,
  output logic [DW-1:0] rdata_o,
  output logic          en_o,
  output logic          dir_o,
  output logic          cmpl_o
);
  logic [ST_W-1:0] st_q, st_d;
  logic [NUM_PTR-1:0][DW-1:0] ptr_q;
  logic wr_csr;

  assign wr_csr = wr_i && (sel_i == SEL_CSR);

  always_comb begin
    st_d = st_q;
    if (wr_csr) begin
      if (wdata_i[CMD_RESET]) begin
        st_d = '0;
      end else begin
        if (wdata_i[CMD_SET_EN])  st_d[ST_EN]  = 1'b1;
        if (wdata_i[CMD_SET_SUP]) st_d[ST_SUP] = 1'b1;
        if (wdata_i[CMD_DIR])     st_d[ST_DIR] = 1'b1;
        if (wdata_i[CMD_CLR_CPL]) st_d[ST_CPL] = 1'b0;
      end
    end
    if (done_i) st_d[ST_CPL] = 1'b1;  // engine event is never lost
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  for (genvar p = 0; p < NUM_PTR; p++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  ptr_q[p] <= '0;
      else if (wr_i && sel_i == reg_sel_e'(p + 1)) ptr_q[p] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i == SEL_CSR) rdata_o = {{(DW-ST_W){1'b0}}, st_q};
    for (int p = 0; p < NUM_PTR; p++) begin
      if (sel_i == reg_sel_e'(p + 1)) rdata_o = ptr_q[p];
    end
  end

  assign en_o   = st_q[ST_EN];
  assign dir_o  = st_q[ST_DIR];
  assign cmpl_o = st_q[ST_CPL];

  a_r7_reset_clears : assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_csr && wdata_i[CMD_RESET] && !done_i |=> st_q == '0);
  a_r3_en_rise_cause : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q[ST_EN]) |-> $past(wr_csr && wdata_i[CMD_SET_EN] && !wdata_i[CMD_RESET]));
  a_r5_dir_sticky : assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q[ST_DIR] && !(wr_csr && wdata_i[CMD_RESET]) |=> st_q[ST_DIR]);
  a_r8_done_sets : assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> st_q[ST_CPL]);
  a_r6_clear_only_cpl : assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_csr && wdata_i[CMD_CLR_CPL] && !wdata_i[CMD_RESET] && !done_i
    |=> !st_q[ST_CPL] && st_q[ST_EN] == $past(st_q[ST_EN] | wdata_i[CMD_SET_EN]));
  a_r2_ptr_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ptr_q));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int CH_SHIFT = 15,
  localparam int CH_BITS = $clog2(NUM_CH),
  localparam int ADDR_W  = CH_SHIFT + CH_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NUM_CH-1:0] done_i,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] dir_o,
  output logic [NUM_CH-1:0] cmpl_o
);
  logic [CH_BITS-1:0] ch;
  reg_sel_e           sel;
  logic [DW-1:0]      ch_rd [NUM_CH];

  dma_reg_decode #(.NUM_CH(NUM_CH), .CH_SHIFT(CH_SHIFT)) u_dec (
    .addr_i (addr_i),
    .size_i (size_i),
    .ch_o   (ch),
    .sel_o  (sel)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_c;
    assign wr_c = req_i && we_i && (sel != SEL_NONE) && (int'(ch) == c);
    dma_chan_slot u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_c),
      .sel_i   (sel),
      .wdata_i (wdata_i),
      .done_i  (done_i[c]),
      .rdata_o (ch_rd[c]),
      .en_o    (en_o[c]),
      .dir_o   (dir_o[c]),
      .cmpl_o  (cmpl_o[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i && sel != SEL_NONE) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (int'(ch) == c) rdata_o = ch_rd[c];
      end
    end
  end

  a_r9_narrow_read_zero : assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && size_i != SIZE_WORD |-> rdata_o == '0);
  a_r10_unmapped_read_zero : assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && sel == SEL_NONE |-> rdata_o == '0);
  a_r11_no_read_when_idle : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> rdata_o == '0);
endmodule

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;
  localparam int NUM_CH = 4;
  localparam int CH_SHIFT = 15;
  localparam int ADDR_W = CH_SHIFT + 2;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [1:0] size = 2'd2;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NUM_CH-1:0] done = '0, en, dir, cmpl;

  int errors = 0, checks = 0;
  bit finished = 0;

  logic [3:0]  m_st  [NUM_CH];
  logic [31:0] m_ptr [NUM_CH][7];
  int ofs_tab [7] = '{'h0, 'h4000, 'h4004, 'h4008, 'h400C, 'h4200, 'h4204};

  always #2.5 clk = ~clk;

  dma_chan_regs #(.NUM_CH(NUM_CH), .CH_SHIFT(CH_SHIFT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .done_i(done),
    .en_o(en), .dir_o(dir), .cmpl_o(cmpl));

  function automatic logic [ADDR_W-1:0] mk(int ch, int ofs);
    return ADDR_W'((ch << CH_SHIFT) | ofs);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [ADDR_W-1:0] a, logic [31:0] d, logic [1:0] sz,
                        logic [NUM_CH-1:0] dn);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d; size = sz; done = dn;
    @(negedge clk);
    req = 0; we = 0; done = '0; size = 2'd2;
  endtask

  task automatic pulse(logic [NUM_CH-1:0] dn);
    @(negedge clk);
    done = dn;
    @(negedge clk);
    done = '0;
  endtask

  task automatic bus_rd(logic [ADDR_W-1:0] a, logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a; size = sz;
    #1 d = rdata;
    @(negedge clk);
    req = 0; size = 2'd2;
  endtask

  function automatic logic [3:0] apply(logic [3:0] s, logic [5:0] cmd);
    logic [3:0] r = s;
    if (cmd[5]) return 4'h0;
    r[2:0] = r[2:0] | cmd[2:0];
    if (cmd[4]) r[3] = 1'b0;
    return r;
  endfunction

  task automatic check_all(string tag);
    logic [31:0] d;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int r = 0; r < 7; r++) begin
        bus_rd(mk(c, ofs_tab[r]), 2'd2, d);
        check($sformatf("%s ch%0d reg%0d", tag, c, r), d,
              r == 0 ? {28'h0, m_st[c]} : m_ptr[c][r]);
      end
      check($sformatf("R11 outputs ch%0d", c), {29'h0, cmpl[c], dir[c], en[c]},
            {29'h0, m_st[c][3], m_st[c][2], m_st[c][0]});
    end
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int c = 0; c < NUM_CH; c++) begin
      m_st[c] = '0;
      for (int r = 0; r < 7; r++) m_ptr[c][r] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check_all("R1 reset");

    // R2 pointer sweep: distinct value per channel and register
    for (int c = 0; c < NUM_CH; c++)
      for (int r = 1; r < 7; r++) begin
        m_ptr[c][r] = 32'h9E3779B9 * (c * 8 + r + 1);
        bus_wr(mk(c, ofs_tab[r]), m_ptr[c][r], 2'd2, '0);
      end
    check_all("R2 ptr sweep");

    // R3 R4 R5 R6 R7: all command codes per channel, model-tracked
    for (int c = 0; c < NUM_CH; c++) begin
      for (int cmd = 0; cmd < 64; cmd++) begin
        if (cmd % 4 == 1) begin
          pulse(NUM_CH'(1) << c);
          m_st[c][3] = 1'b1;
        end
        bus_wr(mk(c, 0), 32'hFFFF_FFC0 | 32'(cmd), 2'd2, '0);
        m_st[c] = apply(m_st[c], 6'(cmd));
        bus_rd(mk(c, 0), 2'd2, d);
        check($sformatf("R3 R4 R5 R6 R7 ch%0d cmd=%0h", c, cmd), d, {28'h0, m_st[c]});
        check($sformatf("R11 en/dir/cpl ch%0d cmd=%0h", c, cmd),
              {29'h0, cmpl[c], dir[c], en[c]},
              {29'h0, m_st[c][3], m_st[c][2], m_st[c][0]});
      end
    end
    check_all("R2 R7 after cmd sweep");

    // R8 done collides with clear-complete, then with reset
    bus_wr(mk(2, 0), 32'h5, 2'd2, '0);
    m_st[2] = apply(m_st[2], 6'h5);
    bus_wr(mk(2, 0), 32'h10, 2'd2, 4'b0100);
    m_st[2][3] = 1'b1;
    bus_rd(mk(2, 0), 2'd2, d);
    check("R8 done beats clear", d, {28'h0, m_st[2]});
    bus_wr(mk(2, 0), 32'h20, 2'd2, 4'b0100);
    m_st[2] = 4'b1000;
    bus_rd(mk(2, 0), 2'd2, d);
    check("R8 done beats reset", d, 32'h8);
    check("R8 cmpl_o", {31'h0, cmpl[2]}, 32'h1);

    // R9 narrow accesses refused
    for (int sz = 0; sz < 4; sz++) begin
      if (sz == 2) continue;
      bus_wr(mk(1, 'h4008), 32'hDEAD_BEEF, 2'(sz), '0);
      bus_wr(mk(1, 0), 32'h3F, 2'(sz), '0);
      bus_rd(mk(1, 'h4008), 2'(sz), d);
      check($sformatf("R9 narrow read sz=%0d", sz), d, 32'h0);
    end
    check_all("R9 after narrow writes");

    // R10 unmapped and unaligned offsets
    begin
      int bad [6] = '{'h4, 'h4010, 'h4208, 'h4002, 'h4201, 'h7FFC};
      foreach (bad[i]) begin
        bus_wr(mk(3, bad[i]), 32'hFFFF_FFFF, 2'd2, '0);
        bus_rd(mk(3, bad[i]), 2'd2, d);
        check($sformatf("R10 unmapped read ofs=%0h", bad[i]), d, 32'h0);
      end
    end
    check_all("R10 after unmapped writes");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule